// File: doc/BRIEF.md
# Coprocessor Access Permission Register

This block holds the 32-bit control word that grants or denies access to the two coprocessors making up the floating-point/SIMD unit. It also contains the combinational gate that decides, for each coprocessor instruction presented to it, whether that instruction must be treated as undefined. Only privileged software may read or write the register. In the non-secure state, each coprocessor's permission field can be updated only when an external per-coprocessor grant input allows it.

Build-time parameters select which of the two coprocessors exist and which unit variant is fitted: none, floating-point only, or floating-point plus SIMD. A permission field that belongs to an absent coprocessor is tied to zero. Software can therefore probe for a coprocessor by writing full access and reading the value back. Two further bits disable the upper half of the double-precision register bank and the instructions that are SIMD-only.

Top module: `cp_access_ctl`

## Requirements
- R1: After reset both permission fields (low coprocessor at bits [21:20], high coprocessor at bits [23:22]) are 00. In the floating-point plus SIMD variant, bits [31:30] are also 00.
- R2: A privileged write to a present coprocessor's field stores the written 2-bit value, including the reserved code 10. A privileged read returns the stored value from the next cycle on.
- R3: When `cfg_priv_i` is low, writes change nothing and `cfg_rdata_o` is zero. `cfg_rdata_o` is also zero whenever `cfg_rd_i` is low.
- R4: The field of an absent coprocessor reads 00 and ignores every write, so writing 11 and reading back 00 reveals that the coprocessor is absent.
- R5: Bits [29:24] and [19:0] always read as zero.
- R6: When `cfg_nonsec_i` is high, a write updates a field only if its grant bit is set (`ns_grant_i[0]` for the low field, `ns_grant_i[1]` for the high field). A non-secure read returns 00 for any field whose grant bit is clear.
- R7: With `ins_valid_i` high, `ins_undef_o` is high unless both fields allow the current mode. Code 11 allows any mode, 01 allows privileged mode only, and 00 and 10 allow no mode.
- R8: Bit 30 set together with `ins_high_bank_i` high makes `ins_undef_o` high.
- R9: Bit 31 set together with `ins_simd_only_i` high makes `ins_undef_o` high.
- R10: In the floating-point-only variant, bits [31:30] read 11, ignore writes and act as set. With no unit fitted, they read 00 and ignore writes.
- R11: `ins_undef_o` is low whenever `ins_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_rd_i | input | 1 | Register read strobe |
| cfg_priv_i | input | 1 | Accessing software is privileged |
| cfg_nonsec_i | input | 1 | Access is made from the non-secure state |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, zero when the read is not allowed |
| ns_grant_i | input | 2 | Per-coprocessor non-secure grant (bit 0 low field, bit 1 high field) |
| ins_valid_i | input | 1 | A coprocessor instruction is being checked |
| ins_priv_i | input | 1 | The instruction executes in privileged mode |
| ins_simd_only_i | input | 1 | The instruction is SIMD and not floating-point |
| ins_high_bank_i | input | 1 | The instruction touches double registers 16 to 31 |
| ins_undef_o | output | 1 | The instruction must be treated as undefined |

## Verification
The hardest case to reach is a non-secure write that arrives with only one grant bit set. That write must update one field and leave the other unchanged. The next read, made with a different grant pattern, must then mask exactly the ungranted field. The bench builds this case directly by sweeping the grant patterns between back-to-back writes and reads. It also runs long random stretches in which the mode, security state and grant bits change every cycle. Three instances with different presence and variant parameters are driven in lockstep, so the probe-by-write behaviour and the tied disable bits are seen under the same stimulus as the full configuration.

// File: rtl/cpac_pkg.sv
package cpac_pkg;
  localparam int NUM_CP     = 2;
  localparam int FLD_W      = 2;
  localparam int FLD_BASE   = 20;   // low coprocessor field LSB, high follows
  localparam int BIT_BANK   = 30;   // upper register bank disable
  localparam int BIT_SIMD   = 31;   // SIMD-only instruction disable

  localparam int VAR_NONE   = 0;
  localparam int VAR_FP     = 1;
  localparam int VAR_FPSIMD = 2;

  typedef enum logic [1:0] {
    PERM_DENY = 2'b00,
    PERM_PRIV = 2'b01,
    PERM_RSVD = 2'b10,
    PERM_ALL  = 2'b11
  } perm_e;
endpackage

// File: rtl/cpac_perm_field.sv
module cpac_perm_field #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [1:0] wdata,
  output logic [1:0] perm_o
);
  generate
    if (PRESENT) begin : g_reg
      logic [1:0] perm_q, perm_d;
      always_comb begin
        perm_d = perm_q;
        if (wr_ok) perm_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) perm_q <= 2'b00;
        else        perm_q <= perm_d;
      end
      assign perm_o = perm_q;
    end else begin : g_absent
      assign perm_o = 2'b00;
    end
  endgenerate
endmodule

// File: rtl/cpac_dis_bits.sv
module cpac_dis_bits #(
  parameter int VARIANT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [1:0] wdata,   // [1] SIMD-only disable, [0] upper bank disable
  output logic [1:0] dis_o
);
  generate
    if (VARIANT == cpac_pkg::VAR_FPSIMD) begin : g_reg
      logic [1:0] dis_q, dis_d;
      always_comb begin
        dis_d = dis_q;
        if (wr_ok) dis_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dis_q <= 2'b00;
        else        dis_q <= dis_d;
      end
      assign dis_o = dis_q;
    end else if (VARIANT == cpac_pkg::VAR_FP) begin : g_fp
      assign dis_o = 2'b11;
    end else begin : g_none
      assign dis_o = 2'b00;
    end
  endgenerate
endmodule

// File: rtl/cpac_gate.sv
module cpac_gate
  import cpac_pkg::*;
#(
  parameter int N = NUM_CP
) (
  input  logic [N-1:0][1:0] perm_i,
  input  logic [1:0]        dis_i,
  input  logic              valid_i,
  input  logic              priv_i,
  input  logic              simd_only_i,
  input  logic              high_bank_i,
  output logic              undef_o
);
  logic [N-1:0] allow;
  logic         perm_fail, bank_fail, simd_fail;

  generate
    for (genvar i = 0; i < N; i++) begin : g_allow
      always_comb begin
        unique case (perm_e'(perm_i[i]))
          PERM_ALL:  allow[i] = 1'b1;
          PERM_PRIV: allow[i] = priv_i;
          default:   allow[i] = 1'b0;   // deny and reserved
        endcase
      end
    end
  endgenerate

  always_comb begin
    perm_fail = ~&allow;
    bank_fail = dis_i[0] & high_bank_i;
    simd_fail = dis_i[1] & simd_only_i;
    undef_o   = valid_i & (perm_fail | bank_fail | simd_fail);
  end
endmodule

// File: rtl/cp_access_ctl.sv
module cp_access_ctl
  import cpac_pkg::*;
#(
  parameter logic [NUM_CP-1:0] CP_PRESENT   = '1,
  parameter int                UNIT_VARIANT = VAR_FPSIMD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              cfg_rd_i,
  input  logic              cfg_priv_i,
  input  logic              cfg_nonsec_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic [NUM_CP-1:0] ns_grant_i,
  input  logic              ins_valid_i,
  input  logic              ins_priv_i,
  input  logic              ins_simd_only_i,
  input  logic              ins_high_bank_i,
  output logic              ins_undef_o
);
  localparam int DW = 32;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [NUM_CP-1:0][1:0] perm;
  logic [NUM_CP-1:0]      fld_wr;
  logic [NUM_CP-1:0][1:0] perm_vis;
  logic [1:0]             dis;
  logic                   dis_wr;
  logic                   rd_ok;

  generate
    for (genvar i = 0; i < NUM_CP; i++) begin : g_fld
      assign fld_wr[i] = cfg_wr_i & cfg_priv_i & (~cfg_nonsec_i | ns_grant_i[i]);
      assign perm_vis[i] = (~cfg_nonsec_i | ns_grant_i[i]) ? perm[i] : 2'b00;

      cpac_perm_field #(.PRESENT(CP_PRESENT[i])) u_fld (
        .clk    (clk),
        .rst_n  (rst_q),
        .wr_ok  (fld_wr[i]),
        .wdata  (cfg_wdata_i[FLD_BASE + FLD_W*i +: FLD_W]),
        .perm_o (perm[i])
      );

      if (CP_PRESENT[i]) begin : g_chk_present
        AST_PRIV_WR_STORES: assert property (@(posedge clk) disable iff (!rst_q)
          fld_wr[i] |=> perm[i] == $past(cfg_wdata_i[FLD_BASE + FLD_W*i +: FLD_W])); // R2
      end else begin : g_chk_absent
        AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
          cfg_rd_i && cfg_priv_i |-> cfg_rdata_o[FLD_BASE + FLD_W*i +: FLD_W] == 2'b00); // R4
      end

      AST_NS_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_q)
        cfg_wr_i && cfg_nonsec_i && !ns_grant_i[i] |=> $stable(perm[i])); // R6
    end
  endgenerate

  assign dis_wr = cfg_wr_i & cfg_priv_i;

  cpac_dis_bits #(.VARIANT(UNIT_VARIANT)) u_dis (
    .clk   (clk),
    .rst_n (rst_q),
    .wr_ok (dis_wr),
    .wdata ({cfg_wdata_i[BIT_SIMD], cfg_wdata_i[BIT_BANK]}),
    .dis_o (dis)
  );

  // read path
  assign rd_ok = cfg_rd_i & cfg_priv_i;
  always_comb begin
    cfg_rdata_o = '0;
    if (rd_ok) begin
      for (int i = 0; i < NUM_CP; i++)
        cfg_rdata_o[FLD_BASE + FLD_W*i +: FLD_W] = perm_vis[i];
      cfg_rdata_o[BIT_BANK] = dis[0];
      cfg_rdata_o[BIT_SIMD] = dis[1];
    end
  end

  cpac_gate #(.N(NUM_CP)) u_gate (
    .perm_i      (perm),
    .dis_i       (dis),
    .valid_i     (ins_valid_i),
    .priv_i      (ins_priv_i),
    .simd_only_i (ins_simd_only_i),
    .high_bank_i (ins_high_bank_i),
    .undef_o     (ins_undef_o)
  );

  AST_UNPRIV_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_wr_i && !cfg_priv_i |=> $stable(perm) && $stable(dis)); // R3
  AST_DENIED_UNDEF: assert property (@(posedge clk) disable iff (!rst_q)
    ins_valid_i && (perm[0] == 2'b00 || perm[1] == 2'b00) |-> ins_undef_o); // R7
  AST_IDLE_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_q)
    !ins_valid_i |-> !ins_undef_o); // R11
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_rdata_o[29:24] == 6'd0 && cfg_rdata_o[19:0] == 20'd0); // R5

  generate
    if (UNIT_VARIANT == VAR_FP) begin : g_chk_fp
      AST_FPONLY_DIS_SET: assert property (@(posedge clk) disable iff (!rst_q)
        cfg_rd_i && cfg_priv_i |-> cfg_rdata_o[31:30] == 2'b11); // R10
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{DW};
endmodule

// File: tb/cp_access_ctl_tb.sv
`timescale 1ns/1ps
module cp_access_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr = 0, rd = 0, priv = 0, ns = 0;
  logic [31:0] wdata = 0;
  logic [1:0]  grant = 0;
  logic        iv = 0, ipriv = 0, isimd = 0, ihigh = 0;

  logic [31:0] rd_o [3];
  logic        ud_o [3];

  int checks = 0, errors = 0;
  string phase = "R1";

  cp_access_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_priv_i(priv),
    .cfg_nonsec_i(ns), .cfg_wdata_i(wdata), .cfg_rdata_o(rd_o[0]), .ns_grant_i(grant),
    .ins_valid_i(iv), .ins_priv_i(ipriv), .ins_simd_only_i(isimd),
    .ins_high_bank_i(ihigh), .ins_undef_o(ud_o[0]));

  cp_access_ctl #(.CP_PRESENT(2'b01), .UNIT_VARIANT(1)) dut_fp_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_priv_i(priv),
    .cfg_nonsec_i(ns), .cfg_wdata_i(wdata), .cfg_rdata_o(rd_o[1]), .ns_grant_i(grant),
    .ins_valid_i(iv), .ins_priv_i(ipriv), .ins_simd_only_i(isimd),
    .ins_high_bank_i(ihigh), .ins_undef_o(ud_o[1]));

  cp_access_ctl #(.CP_PRESENT(2'b00), .UNIT_VARIANT(0)) dut_none_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_priv_i(priv),
    .cfg_nonsec_i(ns), .cfg_wdata_i(wdata), .cfg_rdata_o(rd_o[2]), .ns_grant_i(grant),
    .ins_valid_i(iv), .ins_priv_i(ipriv), .ins_simd_only_i(isimd),
    .ins_high_bank_i(ihigh), .ins_undef_o(ud_o[2]));

  // reference model: configuration tables and state
  int pres_lo [3] = '{1, 1, 0};
  int pres_hi [3] = '{1, 0, 0};
  int unitv   [3] = '{2, 1, 0};
  logic [1:0] m_lo [3];
  logic [1:0] m_hi [3];
  logic [1:0] m_dis [3];
  int since_rst = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      for (int k = 0; k < 3; k++) begin m_lo[k] <= 0; m_hi[k] <= 0; m_dis[k] <= 0; end
    end else begin
      if (since_rst < 10) since_rst <= since_rst + 1;
      if (since_rst >= 2 && wr && priv) begin
        for (int k = 0; k < 3; k++) begin
          if (pres_lo[k] == 1 && (!ns || grant[0])) m_lo[k] <= wdata[21:20];
          if (pres_hi[k] == 1 && (!ns || grant[1])) m_hi[k] <= wdata[23:22];
          if (unitv[k] == 2) m_dis[k] <= wdata[31:30];
        end
      end
    end
  end

  function automatic logic [1:0] eff_dis(int k);
    if (unitv[k] == 2) return m_dis[k];
    if (unitv[k] == 1) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_rd(int k);
    logic [31:0] v = 0;
    if (rd && priv) begin
      v[21:20]  = (!ns || grant[0]) ? m_lo[k] : 2'b00;
      v[23:22]  = (!ns || grant[1]) ? m_hi[k] : 2'b00;
      v[31:30]  = eff_dis(k);
    end
    return v;
  endfunction

  function automatic logic perm_ok(logic [1:0] f, logic p);
    return (f == 2'b11) || (f == 2'b01 && p);
  endfunction

  function automatic logic exp_ud(int k);
    logic [1:0] d = eff_dis(k);
    if (!iv) return 1'b0;
    return !(perm_ok(m_lo[k], ipriv) && perm_ok(m_hi[k], ipriv))
           || (d[0] && ihigh) || (d[1] && isimd);
  endfunction

  task automatic chk(string tag, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic step();
    #1;
    for (int k = 0; k < 3; k++) begin
      chk({phase, " rdata"}, k, rd_o[k], exp_rd(k));
      chk({phase, " undef"}, k, {31'd0, ud_o[k]}, {31'd0, exp_ud(k)});
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr = 0; rd = 0; iv = 0;
  endtask

  task automatic wr_reg(logic p, logic n, logic [1:0] g, logic [31:0] d);
    idle(); wr = 1; priv = p; ns = n; grant = g; wdata = d; step(); idle();
  endtask

  task automatic rd_reg(logic p, logic n, logic [1:0] g);
    idle(); rd = 1; priv = p; ns = n; grant = g; step(); idle();
  endtask

  task automatic ins(logic p, logic s, logic h);
    idle(); iv = 1; ipriv = p; isimd = s; ihigh = h; step(); idle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    phase = "R1 R10";          rd_reg(1, 0, 2'b00);
    phase = "R1 R7";           ins(1, 0, 0);
    phase = "R11";             idle(); step();

    phase = "R2 R4 R5";        wr_reg(1, 0, 2'b00, 32'hFFFF_FFFF); rd_reg(1, 0, 2'b00);
    phase = "R8";              ins(1, 0, 1);
    phase = "R9";              ins(0, 1, 0);
    phase = "R2";              wr_reg(1, 0, 2'b00, 32'h00A0_0000); rd_reg(1, 0, 2'b00);
    phase = "R7";              ins(1, 0, 0);

    phase = "R3";              wr_reg(0, 0, 2'b00, 32'h00F0_0000); rd_reg(1, 0, 2'b00);
                               rd_reg(0, 0, 2'b00);

    phase = "R6";              wr_reg(1, 1, 2'b01, 32'h00F0_0000); rd_reg(1, 0, 2'b00);
                               rd_reg(1, 1, 2'b01); rd_reg(1, 1, 2'b10); rd_reg(1, 1, 2'b00);
                               wr_reg(1, 1, 2'b10, 32'h0050_0000); rd_reg(1, 1, 2'b11);
                               wr_reg(1, 1, 2'b00, 32'h0000_0000); rd_reg(1, 0, 2'b00);

    phase = "R7";              wr_reg(1, 0, 2'b00, 32'h0050_0000);
                               ins(0, 0, 0); ins(1, 0, 0);
                               wr_reg(1, 0, 2'b00, 32'h00F0_0000);
                               ins(0, 0, 0); wr_reg(1, 0, 2'b00, 32'h00C0_0000); ins(1, 0, 0);
    phase = "R8 R9 R10";       wr_reg(1, 0, 2'b00, 32'h40F0_0000);
                               ins(1, 0, 1); ins(1, 1, 0); rd_reg(1, 0, 2'b00);
                               wr_reg(1, 0, 2'b00, 32'h80F0_0000);
                               ins(1, 1, 0); ins(1, 0, 1);
                               wr_reg(1, 0, 2'b00, 32'h00F0_0000); ins(1, 1, 1);
    phase = "R11";             idle(); isimd = 1; ihigh = 1; step();

    phase = "R2 R3 R6 R7 R8 R9";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      wr = r[0]; rd = r[1]; priv = r[2] | r[3]; ns = r[4]; grant = r[6:5];
      iv = r[7] | r[8]; ipriv = r[9]; isimd = r[10] & r[11]; ihigh = r[12] & r[13];
      wdata = $urandom;
      step();
    end
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule